// File: doc/BRIEF.md
# DS3/E3 Transmit Maintenance Signal Generator

This block is a bit-serial transmit framer. It builds either a DS3 M-frame or an E3 frame from a payload bit stream supplied one bit per clock. It counts bit positions inside the frame and inserts the overhead bits: framing, multiframe, X, P and C bits for DS3, and the alignment word, remote alarm bit and national bit for E3. When maintenance signalling is requested, it puts the selected test pattern in place of the payload. The DS3 P bits are computed over the payload bits that actually went out on the line, so a maintenance pattern carries correct parity.

The payload side is a pull interface. The block raises `pl_req` in every cycle whose bit position is a payload slot that no maintenance pattern replaces, and it samples `pl_bit` in that same cycle. The source cannot apply back-pressure, and the framer never waits. A source that has no data must still present a bit, because the line runs at a fixed rate. The HDLC and FEAC sides are plain one-bit inputs, sampled in the cycle where their overhead slot is emitted. Each serial output bit leaves one clock after its position is processed. `tx_sof` marks the first bit of every frame.

Top module: `ds3e3_maint_tx`

## Requirements
- R1: While `rst_n` is low, `tx_bit`, `tx_sof` and `pl_req` are 0. After release, the first frame is DS3 and starts at its first bit.
- R2: A DS3 frame is 4760 bits long. It is 7 subframes, and each subframe is 8 blocks of one overhead bit followed by 84 payload bits. The overhead of blocks 2, 4, 6 and 8 is F = 1, 0, 0, 1. In subframes 5, 6 and 7 the block-1 bit is M = 0, 1, 0. `tx_sof` is 1 exactly on the first bit of each frame.
- R3: The block-1 bits of subframes 3 and 4 (both P bits) equal the XOR of all 4704 payload bits sent in the previous frame. They are 0 when the previous frame was E3 or when there was no previous frame.
- R4: The block-1 bits of subframes 1 and 2 (X bits) are the inverse of `rai_en`. Under AIS or idle they are 1.
- R5: C bits sit at blocks 3, 5 and 7. With `cbit_en` = 0 they are all 0. With `cbit_en` = 1:
  - subframe 1 sends 1, 1, `feac_bit`;
  - subframe 3 sends the P value three times;
  - subframe 5 sends `hdlc_bit` three times;
  - every other C bit is 1.
- R6: In DS3 with `ais_en` = 1, payload bit k of a block (k = 0..83) is 1 when k is even and 0 otherwise. All C bits are 0, X bits are 1, and F, M and P bits are unchanged.
- R7: In DS3 with `idle_en` = 1 and `ais_en` = 0, payload bit k is 1 when k mod 4 is below 2. The subframe-3 C bits are 0, the other C bits follow R5, and X bits are 1. AIS overrides idle.
- R8: An E3 frame is 1536 bits long. Bits 1 to 10 are 1111010000 (sent left first), bit 11 equals `rai_en`, bit 12 is the national bit, and bits 13 to 1536 are payload. `idle_en` and `cbit_en` have no effect in E3.
- R9: The E3 national bit follows `nat_sel`: 00 gives 1, 01 gives `hdlc_bit`, 10 gives `feac_bit`, 11 gives 0. `nat_sel` has no effect in DS3.
- R10: In E3 with `ais_en` = 1, every output bit is 1, including the alignment positions. `tx_sof` still marks the frame start.
- R11: `pl_req` is 1 exactly on payload positions with no pattern active. The bit sampled there appears on `tx_bit` on the following clock.
- R12: `mode_sel` (0 = DS3, 1 = E3) is sampled in the last bit cycle of each frame and applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Line format for the next frame, 0 = DS3, 1 = E3 |
| ais_en | input | 1 | Send alarm indication signal |
| rai_en | input | 1 | Send remote alarm indication |
| idle_en | input | 1 | Send DS3 idle signal |
| cbit_en | input | 1 | Enable the C-bit channels in DS3 |
| nat_sel | input | 2 | E3 national bit source |
| hdlc_bit | input | 1 | Data link bit for its overhead slot |
| feac_bit | input | 1 | Alarm/command channel bit for its overhead slot |
| pl_bit | input | 1 | Payload bit, taken when `pl_req` is 1 |
| pl_req | output | 1 | Payload bit requested in this cycle |
| tx_bit | output | 1 | Serial line bit |
| tx_sof | output | 1 | First bit of a frame on `tx_bit` |

## Verification
The embedded properties watch a few rules on every cycle:
- the position counters restart after each frame end and the frame-start pulse follows two clocks later;
- the line format and the held parity change only at a frame boundary;
- the payload is never requested while AIS is active;
- E3 AIS gives all ones;
- remote alarm clears the X bits.

The exact bit values need the bench's reference model, which follows every position of whole frames. These are the F/M/C layout, the parity carried from one frame into the next, the alternating and paired pattern phases, the national bit selection and the deferred mode change.

// File: rtl/ds3e3_tx_pkg.sv
package ds3e3_tx_pkg;
  typedef enum logic {
    LM_DS3 = 1'b0,
    LM_E3  = 1'b1
  } line_mode_e;

  typedef enum logic [1:0] {
    NS_ONE  = 2'b00,
    NS_HDLC = 2'b01,
    NS_FEAC = 2'b10,
    NS_ZERO = 2'b11
  } nat_sel_e;

  // E3 alignment word, most significant bit leaves first
  localparam int          E3_ALIGN_BITS = 10;
  localparam logic [9:0]  E3_ALIGN      = 10'b1111010000;
  localparam int          E3_RAI_POS    = 10;
  localparam int          E3_NAT_POS    = 11;
endpackage

// File: rtl/ds3e3_frame_ctr.sv
module ds3e3_frame_ctr
  import ds3e3_tx_pkg::*;
#(
  parameter int PAY_BITS  = 84,
  parameter int BLOCKS    = 8,
  parameter int SUBFRAMES = 7,
  parameter int E3_BITS   = 1536,
  parameter int BW        = 7,
  parameter int KW        = 3,
  parameter int SW        = 3,
  parameter int EW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  output logic [BW-1:0] bit_idx,
  output logic [KW-1:0] blk,
  output logic [SW-1:0] sf,
  output logic [EW-1:0] e3_pos,
  output line_mode_e    mode_q,
  output logic          wrap,
  output logic          at_start
);
  localparam logic [BW-1:0] BIT_MAX = BW'(PAY_BITS);
  localparam logic [KW-1:0] BLK_MAX = KW'(BLOCKS - 1);
  localparam logic [SW-1:0] SF_MAX  = SW'(SUBFRAMES - 1);
  localparam logic [EW-1:0] E3_MAX  = EW'(E3_BITS - 1);

  logic ds3_last, e3_last;

  assign ds3_last = (bit_idx == BIT_MAX) && (blk == BLK_MAX) && (sf == SF_MAX);
  assign e3_last  = (e3_pos == E3_MAX);
  assign wrap     = (mode_q == LM_E3) ? e3_last : ds3_last;
  assign at_start = (bit_idx == '0) && (blk == '0) && (sf == '0) && (e3_pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx <= '0;
      blk     <= '0;
      sf      <= '0;
      e3_pos  <= '0;
      mode_q  <= LM_DS3;
    end else if (wrap) begin
      bit_idx <= '0;
      blk     <= '0;
      sf      <= '0;
      e3_pos  <= '0;
      mode_q  <= line_mode_e'(mode_in);
    end else if (mode_q == LM_E3) begin
      e3_pos <= e3_pos + 1'b1;
    end else if (bit_idx == BIT_MAX) begin
      bit_idx <= '0;
      if (blk == BLK_MAX) begin
        blk <= '0;
        sf  <= sf + 1'b1;
      end else begin
        blk <= blk + 1'b1;
      end
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  // R2
  restart_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> at_start);

  // R12
  mode_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(mode_q));
endmodule

// File: rtl/ds3e3_ds3_gen.sv
module ds3e3_ds3_gen #(
  parameter int BLOCKS = 8,
  parameter int BW     = 7,
  parameter int KW     = 3,
  parameter int SW     = 3
) (
  input  logic [BW-1:0] bit_idx,
  input  logic [KW-1:0] blk,
  input  logic [SW-1:0] sf,
  input  logic          ais,
  input  logic          rai,
  input  logic          idle,
  input  logic          cbit_on,
  input  logic          par,
  input  logic          feac,
  input  logic          hdlc,
  input  logic          pl_bit,
  output logic          out_bit,
  output logic          pay_pos,
  output logic          take_pl,
  output logic          x_pos
);
  localparam logic [KW-1:0] BLK_LAST = KW'(BLOCKS - 1);

  logic [1:0]    phase;
  logic [KW-2:0] cnum;
  logic          x_val, f_val, c_val, m_val;

  assign pay_pos = (bit_idx != '0);
  assign phase   = bit_idx[1:0] - 2'd1;
  assign take_pl = pay_pos && !ais && !idle;
  assign x_pos   = !pay_pos && (blk == '0) && (sf < SW'(2));
  assign x_val   = (ais || idle) ? 1'b1 : !rai;
  assign f_val   = (blk == KW'(1)) || (blk == BLK_LAST);
  assign cnum    = blk[KW-1:1] - 1'b1;

  always_comb begin
    if (sf == SW'(5)) m_val = 1'b1;
    else              m_val = 1'b0;
  end

  always_comb begin
    c_val = 1'b1;
    if (ais || !cbit_on) begin
      c_val = 1'b0;
    end else if (idle && (sf == SW'(2))) begin
      c_val = 1'b0;
    end else if (sf == SW'(0)) begin
      c_val = (cnum == (KW-1)'(2)) ? feac : 1'b1;
    end else if (sf == SW'(2)) begin
      c_val = par;
    end else if (sf == SW'(4)) begin
      c_val = hdlc;
    end
  end

  always_comb begin
    if (pay_pos) begin
      if (ais)       out_bit = !phase[0];
      else if (idle) out_bit = !phase[1];
      else           out_bit = pl_bit;
    end else if (blk == '0) begin
      if (sf < SW'(2))      out_bit = x_val;
      else if (sf < SW'(4)) out_bit = par;
      else                  out_bit = m_val;
    end else if (blk[0]) begin
      out_bit = f_val;
    end else begin
      out_bit = c_val;
    end
  end
endmodule

// File: rtl/ds3e3_e3_gen.sv
module ds3e3_e3_gen
  import ds3e3_tx_pkg::*;
#(
  parameter int EW = 11
) (
  input  logic [EW-1:0] e3_pos,
  input  logic          ais,
  input  logic          rai,
  input  logic [1:0]    nat_sel,
  input  logic          feac,
  input  logic          hdlc,
  input  logic          pl_bit,
  output logic          out_bit,
  output logic          take_pl
);
  logic nat_val;
  logic [3:0] align_idx;

  assign align_idx = 4'(E3_ALIGN_BITS - 1) - e3_pos[3:0];

  always_comb begin
    case (nat_sel_e'(nat_sel))
      NS_ONE:  nat_val = 1'b1;
      NS_HDLC: nat_val = hdlc;
      NS_FEAC: nat_val = feac;
      default: nat_val = 1'b0;
    endcase
  end

  always_comb begin
    take_pl = 1'b0;
    if (ais) begin
      out_bit = 1'b1;
    end else if (e3_pos < EW'(E3_ALIGN_BITS)) begin
      out_bit = E3_ALIGN[align_idx];
    end else if (e3_pos == EW'(E3_RAI_POS)) begin
      out_bit = rai;
    end else if (e3_pos == EW'(E3_NAT_POS)) begin
      out_bit = nat_val;
    end else begin
      out_bit = pl_bit;
      take_pl = 1'b1;
    end
  end
endmodule

// File: rtl/ds3e3_parity.sv
module ds3e3_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic line_bit,
  input  logic wrap,
  output logic p_hold
);
  logic acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= 1'b0;
      p_hold <= 1'b0;
    end else if (wrap) begin
      p_hold <= acc ^ (count_en & line_bit);
      acc    <= 1'b0;
    end else if (count_en) begin
      acc <= acc ^ line_bit;
    end
  end

  // R3
  parity_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(p_hold));
endmodule

// File: rtl/ds3e3_maint_tx.sv
module ds3e3_maint_tx
  import ds3e3_tx_pkg::*;
#(
  parameter int DS3_PAY_BITS  = 84,
  parameter int DS3_BLOCKS    = 8,
  parameter int DS3_SUBFRAMES = 7,
  parameter int E3_FRAME_BITS = 1536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  input  logic       ais_en,
  input  logic       rai_en,
  input  logic       idle_en,
  input  logic       cbit_en,
  input  logic [1:0] nat_sel,
  input  logic       hdlc_bit,
  input  logic       feac_bit,
  input  logic       pl_bit,
  output logic       pl_req,
  output logic       tx_bit,
  output logic       tx_sof
);
  localparam int BW = $clog2(DS3_PAY_BITS + 1);
  localparam int KW = $clog2(DS3_BLOCKS);
  localparam int SW = $clog2(DS3_SUBFRAMES);
  localparam int EW = $clog2(E3_FRAME_BITS);

  logic [BW-1:0] bit_idx;
  logic [KW-1:0] blk;
  logic [SW-1:0] sf;
  logic [EW-1:0] e3_pos;
  line_mode_e    mode_q;
  logic          wrap, at_start;
  logic          ds3_bit, ds3_pay, ds3_take, x_pos;
  logic          e3_bit, e3_take;
  logic          p_hold, next_bit, is_ds3;

  ds3e3_frame_ctr #(
    .PAY_BITS(DS3_PAY_BITS), .BLOCKS(DS3_BLOCKS), .SUBFRAMES(DS3_SUBFRAMES),
    .E3_BITS(E3_FRAME_BITS), .BW(BW), .KW(KW), .SW(SW), .EW(EW)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_sel),
    .bit_idx(bit_idx), .blk(blk), .sf(sf), .e3_pos(e3_pos),
    .mode_q(mode_q), .wrap(wrap), .at_start(at_start)
  );

  ds3e3_ds3_gen #(.BLOCKS(DS3_BLOCKS), .BW(BW), .KW(KW), .SW(SW)) u_ds3 (
    .bit_idx(bit_idx), .blk(blk), .sf(sf),
    .ais(ais_en), .rai(rai_en), .idle(idle_en), .cbit_on(cbit_en),
    .par(p_hold), .feac(feac_bit), .hdlc(hdlc_bit), .pl_bit(pl_bit),
    .out_bit(ds3_bit), .pay_pos(ds3_pay), .take_pl(ds3_take), .x_pos(x_pos)
  );

  ds3e3_e3_gen #(.EW(EW)) u_e3 (
    .e3_pos(e3_pos), .ais(ais_en), .rai(rai_en), .nat_sel(nat_sel),
    .feac(feac_bit), .hdlc(hdlc_bit), .pl_bit(pl_bit),
    .out_bit(e3_bit), .take_pl(e3_take)
  );

  assign is_ds3   = (mode_q == LM_DS3);
  assign next_bit = is_ds3 ? ds3_bit : e3_bit;
  assign pl_req   = is_ds3 ? ds3_take : e3_take;

  ds3e3_parity u_par (
    .clk(clk), .rst_n(rst_n), .count_en(is_ds3 && ds3_pay),
    .line_bit(next_bit), .wrap(wrap), .p_hold(p_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit <= 1'b0;
      tx_sof <= 1'b0;
    end else begin
      tx_bit <= next_bit;
      tx_sof <= at_start;
    end
  end

  // R2
  sof_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ##1 tx_sof);

  // R11
  no_req_under_ais_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req |-> !ais_en);

  // R10
  e3_ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ds3 && ais_en) |=> tx_bit);

  // R4
  x_cleared_by_rai_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ds3 && x_pos && rai_en && !ais_en && !idle_en) |=> !tx_bit);
endmodule

// File: tb/ds3e3_maint_tx_bench.sv
module ds3e3_maint_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0, ais_en = 1'b0, rai_en = 1'b0, idle_en = 1'b0, cbit_en = 1'b0;
  logic [1:0] nat_sel = 2'b00;
  logic       hdlc_bit = 1'b0, feac_bit = 1'b0, pl_bit = 1'b0;
  logic       pl_req, tx_bit, tx_sof;

  always #10 clk = ~clk;

  ds3e3_maint_tx u_ds3e3_maint_tx (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ais_en(ais_en),
    .rai_en(rai_en), .idle_en(idle_en), .cbit_en(cbit_en), .nat_sel(nat_sel),
    .hdlc_bit(hdlc_bit), .feac_bit(feac_bit), .pl_bit(pl_bit),
    .pl_req(pl_req), .tx_bit(tx_bit), .tx_sof(tx_sof)
  );

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  // control values applied at the next cycle
  bit    c_mode = 0, c_ais = 0, c_rai = 0, c_idle = 0, c_cb = 0;
  bit [1:0] c_nsel = 0;
  // reference model state
  int    m_pos = 0;
  bit    m_mode = 0, m_acc = 0, m_par = 0, have_prev = 0;
  bit    e_bit, e_sof, e_req;
  string e_tag, e_sof_tag, cur_sof_tag = "R2";

  task automatic chk(bit got, bit exp, string tag, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s at pos %0d: got %0d expected %0d", tag, what, m_pos, got, exp);
    end
  endtask

  task automatic model();
    int sf, r, blk, k, i, c, last;
    bit b, pay;
    string t;
    pay = 0; e_req = 0;
    last = m_mode ? 1535 : 4759;
    e_sof = (m_pos == 0);
    e_sof_tag = cur_sof_tag;
    if (!m_mode) begin
      sf = m_pos / 680; r = m_pos % 680; blk = r / 85; k = r % 85;
      if (k > 0) begin
        pay = 1; i = k - 1;
        if (ais_en)       begin b = (i % 2 == 0); t = "R6"; end
        else if (idle_en) begin b = (i % 4 < 2);  t = "R7"; end
        else begin b = pl_bit; e_req = 1; t = "R11"; end
      end else if (blk == 0) begin
        if (sf < 2)      begin b = (ais_en || idle_en) ? 1'b1 : !rai_en; t = "R4"; end
        else if (sf < 4) begin b = m_par; t = "R3"; end
        else             begin b = (sf == 5); t = "R2"; end
      end else if (blk % 2 == 1) begin
        b = (blk == 1 || blk == 7); t = "R2";
      end else begin
        c = blk / 2 - 1;
        if (ais_en)                    begin b = 0; t = "R6"; end
        else if (!cbit_en)             begin b = 0; t = "R5"; end
        else if (idle_en && sf == 2)   begin b = 0; t = "R7"; end
        else begin
          t = "R5";
          case (sf)
            0: b = (c == 2) ? feac_bit : 1'b1;
            2: b = m_par;
            4: b = hdlc_bit;
            default: b = 1'b1;
          endcase
        end
      end
    end else begin
      if (ais_en) begin b = 1; t = "R10"; end
      else if (m_pos < 10) begin b = (m_pos < 4) || (m_pos == 5); t = "R8"; end
      else if (m_pos == 10) begin b = rai_en; t = "R8"; end
      else if (m_pos == 11) begin
        t = "R9";
        case (nat_sel)
          2'b00: b = 1; 2'b01: b = hdlc_bit; 2'b10: b = feac_bit; default: b = 0;
        endcase
      end else begin b = pl_bit; e_req = 1; t = "R11"; end
    end
    e_bit = b; e_tag = t;
    if (!m_mode && pay) m_acc = m_acc ^ b;
    if (m_pos == last) begin
      m_par = m_mode ? 1'b0 : m_acc;
      m_acc = 0;
      cur_sof_tag = (mode_sel != m_mode) ? "R12" : (mode_sel ? "R8" : "R2");
      m_mode = mode_sel;
      m_pos = 0;
    end else begin
      m_pos++;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    if (have_prev) begin
      chk(tx_bit, e_bit, e_tag, "tx_bit");
      chk(tx_sof, e_sof, e_sof_tag, "tx_sof");
    end
    mode_sel = c_mode; ais_en = c_ais; rai_en = c_rai; idle_en = c_idle;
    cbit_en = c_cb; nat_sel = c_nsel;
    pl_bit = 1'($urandom); hdlc_bit = 1'($urandom); feac_bit = 1'($urandom);
    #1;
    model();
    chk(pl_req, e_req, "R11", "pl_req");
    have_prev = 1;
  endtask

  // one whole frame in the current mode; mode_sel toggles mid-frame (R12)
  task automatic frame(bit a, bit r, bit i, bit cb, bit [1:0] ns, bit nxt);
    int len;
    len = m_mode ? 1536 : 4760;
    c_ais = a; c_rai = r; c_idle = i; c_cb = cb; c_nsel = ns;
    for (int n = 0; n < len; n++) begin
      c_mode = (n < len / 2) ? !nxt : nxt;
      cycle();
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1
    chk(tx_bit, 1'b0, "R1", "tx_bit in reset");
    chk(tx_sof, 1'b0, "R1", "tx_sof in reset");
    chk(pl_req, 1'b0, "R1", "pl_req in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    frame(0, 0, 0, 0, 2'b01, 0);   // DS3 plain, P from none
    frame(0, 1, 0, 1, 2'b10, 0);   // RAI, C channels
    frame(1, 0, 0, 1, 2'b00, 0);   // AIS
    frame(0, 1, 1, 1, 2'b11, 0);   // idle with C channels
    frame(1, 0, 1, 0, 2'b00, 0);   // AIS over idle
    frame(0, 0, 0, 1, 2'b00, 1);   // then switch to E3
    frame(0, 0, 1, 1, 2'b00, 1);   // E3 nsel 00, idle ignored
    frame(0, 1, 0, 0, 2'b01, 1);
    frame(0, 0, 0, 0, 2'b10, 1);
    frame(0, 1, 1, 0, 2'b11, 1);
    frame(1, 0, 0, 0, 2'b00, 1);   // E3 AIS
    frame(0, 0, 0, 0, 2'b00, 0);   // back to DS3, P = 0
    frame(0, 0, 0, 1, 2'b00, 0);
    for (int f = 0; f < 8; f++)
      frame(1'($urandom % 4 == 0), 1'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom));
    cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule